// File: doc/BRIEF.md
# Multi-Mode Scan Sequencer

This block decides which analog channel is converted next and how often the channel list is walked. It reads an eight-entry table of 4-bit channel numbers and issues one conversion-start pulse at a time to an external converter, together with the channel code for that conversion. When the converter answers with a done strobe, the sequencer forwards the returned sample tagged with the table slot it belongs to, then moves on to the next slot or stops.

The run is governed by a software start bit held inside the block. Software sets or clears it through a write strobe, and the block clears it on its own when a finite run completes. Three run behaviours exist. The first converts the channel in slot 0 once. The second walks all eight slots once. The third walks the table repeatedly until software stops it. A down-sample enable forces the repeating behaviour whatever the mode field holds. After each finished single conversion or each finished pass through the table, an end-of-conversion interrupt pulse is raised if interrupts are enabled. With the converter enable low, nothing is issued.

Top module: `scan_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, start_bit, conv_start, ch_sel, res_valid, res_slot, res_data and eoc_irq are all 0.
- R2: With run_mode 0 (one conversion) or 1 (the reserved code, treated the same way), setting the start bit gives exactly one conv_start, with ch_sel taken from seq_table[3:0].
- R3: With run_mode 2 (one pass), slots 0 to 7 are converted in order, slot k using the channel in seq_table[4k+3:4k]. That is eight conversions, after which the run ends.
- R4: With run_mode 3 (repeating pass), slot 7 is followed by slot 0 and start_bit stays 1 until software writes 0.
- R5: With ds_en at 1, the sequencer repeats the pass as in R4 for any run_mode value.
- R6: A write of 0 to the start bit (sw_wr with sw_val 0) stops the run in the same cycle and returns the sequencer to slot 0. No conv_start follows, and a done strobe arriving for an abandoned conversion produces no res_valid.
- R7: While conv_en is 0, no conv_start is issued, and a set start bit waits. The run begins once conv_en returns to 1.
- R8: conv_start is a single-cycle pulse. No further conv_start is issued until conv_done has answered the previous one.
- R9: conv_done in cycle t gives res_valid in cycle t+1, with res_slot equal to the slot that was converted and res_data equal to conv_data as sampled in cycle t.
- R10: eoc_irq pulses for one cycle, together with res_valid, at the result that ends a single conversion or a pass, and only if irq_en is 1.
- R11: In the finite modes, start_bit reads 0 from the cycle after the final conv_done. A software write in that same cycle takes precedence over the hardware clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_en | input | 1 | Converter enable; nothing runs while 0 |
| irq_en | input | 1 | End-of-conversion interrupt enable |
| sw_wr | input | 1 | Software write strobe for the start bit |
| sw_val | input | 1 | Value written to the start bit |
| run_mode | input | 2 | 0 one conversion, 1 treated as 0, 2 one pass, 3 repeating pass |
| ds_en | input | 1 | Down-sample enable, forces the repeating pass |
| seq_table | input | 32 | Eight 4-bit channel numbers, slot 0 in bits 3:0 |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter sample, valid with conv_done |
| start_bit | output | 1 | Current value of the start bit |
| conv_start | output | 1 | Conversion start pulse |
| ch_sel | output | 4 | Channel code for the issued conversion |
| res_valid | output | 1 | Routed result strobe |
| res_slot | output | 3 | Slot index of the routed result |
| res_data | output | 12 | Routed sample |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
A wrong slot counter shows on ch_sel at the next conv_start and on res_slot one cycle after the matching done. Both are therefore visible within one conversion latency. A corrupted busy flag shows as an extra or missing conv_start in the very next cycle. A wrong mode decode or a wrong pass-end decision shows at the end of a pass as a missing or stray eoc_irq and as start_bit dropping one cycle after the final done or failing to drop. The bench compares every output against a behavioural model on each clock, so any such divergence is caught in the cycle it appears.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        RUN_ONE  = 2'd0,
        RUN_PASS = 2'd1,
        RUN_LOOP = 2'd2
    } run_kind_e;

    localparam logic [1:0] MODE_ONE      = 2'd0;
    localparam logic [1:0] MODE_RESERVED = 2'd1;
    localparam logic [1:0] MODE_PASS     = 2'd2;
    localparam logic [1:0] MODE_LOOP     = 2'd3;

endpackage

// File: rtl/scan_seq_mode_dec.sv
module scan_seq_mode_dec
    import scan_seq_pkg::*;
(
    input  logic [1:0] run_mode,
    input  logic       ds_en,
    output run_kind_e  run_kind
);

    always_comb begin
        if (ds_en) begin
            run_kind = RUN_LOOP;
        end else begin
            unique case (run_mode)
                MODE_LOOP:     run_kind = RUN_LOOP;
                MODE_PASS:     run_kind = RUN_PASS;
                MODE_RESERVED: run_kind = RUN_ONE;
                default:       run_kind = RUN_ONE;
            endcase
        end
    end

endmodule

// File: rtl/scan_seq_slot_mux.sv
module scan_seq_slot_mux #(
    parameter int NSLOT = 8,
    parameter int CH_W  = 4,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT*CH_W-1:0] seq_table,
    input  logic [SLOT_W-1:0]     slot,
    output logic [CH_W-1:0]       ch
);

    logic [CH_W-1:0] entry [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_entry
        assign entry[g] = seq_table[g*CH_W +: CH_W];
    end

    always_comb begin
        ch = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot == SLOT_W'(i)) ch = entry[i];
        end
    end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int CH_W   = 4,
    parameter int DATA_W = 12,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_en,
    input  logic              irq_en,
    input  logic              sw_wr,
    input  logic              sw_val,
    input  run_kind_e         run_kind,
    input  logic [CH_W-1:0]   ch_now,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [SLOT_W-1:0] slot,
    output logic              start_bit,
    output logic              conv_start,
    output logic [CH_W-1:0]   ch_sel,
    output logic              res_valid,
    output logic [SLOT_W-1:0] res_slot,
    output logic [DATA_W-1:0] res_data,
    output logic              eoc_irq
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

    typedef struct packed {
        logic              start;
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic              issue;
        logic [CH_W-1:0]   ch;
        logic              rvalid;
        logic [SLOT_W-1:0] rslot;
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic       halt;
    logic       pass_end;

    always_comb begin
        st_d        = st_q;
        st_d.issue  = 1'b0;
        st_d.rvalid = 1'b0;
        st_d.irq    = 1'b0;

        halt     = !conv_en || !st_q.start || (sw_wr && !sw_val);
        pass_end = (run_kind == RUN_ONE) || (st_q.slot == LAST_SLOT);

        if (halt) begin
            st_d.busy = 1'b0;
            st_d.slot = '0;
        end else if (!st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.issue = 1'b1;
            st_d.ch    = ch_now;
        end else if (conv_done) begin
            st_d.busy   = 1'b0;
            st_d.rvalid = 1'b1;
            st_d.rslot  = st_q.slot;
            st_d.rdata  = conv_data;
            if (pass_end) begin
                st_d.slot = '0;
                st_d.irq  = irq_en;
                if (run_kind != RUN_LOOP) st_d.start = 1'b0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end

        if (sw_wr) st_d.start = sw_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot       = st_q.slot;
    assign start_bit  = st_q.start;
    assign conv_start = st_q.issue;
    assign ch_sel     = st_q.ch;
    assign res_valid  = st_q.rvalid;
    assign res_slot   = st_q.rslot;
    assign res_data   = st_q.rdata;
    assign eoc_irq    = st_q.irq;

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_seq_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int CH_W   = 4,
    parameter int DATA_W = 12,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  conv_en,
    input  logic                  irq_en,
    input  logic                  sw_wr,
    input  logic                  sw_val,
    input  logic [1:0]            run_mode,
    input  logic                  ds_en,
    input  logic [NSLOT*CH_W-1:0] seq_table,
    input  logic                  conv_done,
    input  logic [DATA_W-1:0]     conv_data,
    output logic                  start_bit,
    output logic                  conv_start,
    output logic [CH_W-1:0]       ch_sel,
    output logic                  res_valid,
    output logic [SLOT_W-1:0]     res_slot,
    output logic [DATA_W-1:0]     res_data,
    output logic                  eoc_irq
);

    run_kind_e         run_kind;
    logic [SLOT_W-1:0] cur_slot;
    logic [CH_W-1:0]   ch_now;

    scan_seq_mode_dec u_mode (
        .run_mode (run_mode),
        .ds_en    (ds_en),
        .run_kind (run_kind)
    );

    scan_seq_slot_mux #(.NSLOT(NSLOT), .CH_W(CH_W)) u_mux (
        .seq_table (seq_table),
        .slot      (cur_slot),
        .ch        (ch_now)
    );

    scan_seq_ctrl #(.NSLOT(NSLOT), .CH_W(CH_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_en    (conv_en),
        .irq_en     (irq_en),
        .sw_wr      (sw_wr),
        .sw_val     (sw_val),
        .run_kind   (run_kind),
        .ch_now     (ch_now),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .slot       (cur_slot),
        .start_bit  (start_bit),
        .conv_start (conv_start),
        .ch_sel     (ch_sel),
        .res_valid  (res_valid),
        .res_slot   (res_slot),
        .res_data   (res_data),
        .eoc_irq    (eoc_irq)
    );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_en,
    input logic irq_en,
    input logic sw_wr,
    input logic conv_done,
    input logic start_bit,
    input logic conv_start,
    input logic res_valid,
    input logic eoc_irq
);

    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                        pending_q <= 1'b0;
        else if (conv_start)               pending_q <= 1'b1;
        else if (conv_done || !start_bit || !conv_en) pending_q <= 1'b0;
    end

    AST_START_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pending_q); // R8

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> !conv_start); // R7

    AST_RESULT_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(conv_done)); // R9

    AST_IRQ_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> (res_valid && $past(irq_en))); // R10

    AST_HW_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_bit) && !$past(sw_wr)) |-> $past(conv_done)); // R11

endmodule

bind scan_seq scan_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_en    (conv_en),
    .irq_en     (irq_en),
    .sw_wr      (sw_wr),
    .conv_done  (conv_done),
    .start_bit  (start_bit),
    .conv_start (conv_start),
    .res_valid  (res_valid),
    .eoc_irq    (eoc_irq)
);

// File: tb/scan_seq_bench.sv
module scan_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TABLE = 32'h7A3C_5E91;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        sw_wr = 1'b0;
    logic        sw_val = 1'b0;
    logic [1:0]  run_mode = 2'd0;
    logic        ds_en = 1'b0;
    logic [31:0] seq_table = TABLE;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        start_bit, conv_start, res_valid, eoc_irq;
    logic [3:0]  ch_sel;
    logic [2:0]  res_slot;
    logic [11:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_seq u_scan_seq (
        .clk (clk), .rst_n (rst_n), .conv_en (conv_en), .irq_en (irq_en),
        .sw_wr (sw_wr), .sw_val (sw_val), .run_mode (run_mode), .ds_en (ds_en),
        .seq_table (seq_table), .conv_done (conv_done), .conv_data (conv_data),
        .start_bit (start_bit), .conv_start (conv_start), .ch_sel (ch_sel),
        .res_valid (res_valid), .res_slot (res_slot), .res_data (res_data),
        .eoc_irq (eoc_irq)
    );

    // behavioural reference model, advanced on each rising edge
    int m_start, m_busy, m_slot, m_cs, m_ch, m_rv, m_rslot, m_rdata, m_irq;

    always @(posedge clk) begin
        int loop_mode, one_mode, stopping, ending;
        if (!rst_n) begin
            m_start = 0; m_busy = 0; m_slot = 0; m_cs = 0; m_ch = 0;
            m_rv = 0; m_rslot = 0; m_rdata = 0; m_irq = 0;
        end else begin
            m_cs = 0; m_rv = 0; m_irq = 0;
            loop_mode = (ds_en || run_mode == 2'd3) ? 1 : 0;
            one_mode  = (!ds_en && run_mode <= 2'd1) ? 1 : 0;
            stopping  = (!conv_en || m_start == 0 || (sw_wr && !sw_val)) ? 1 : 0;
            if (stopping != 0) begin
                m_busy = 0; m_slot = 0;
            end else if (m_busy == 0) begin
                m_busy = 1; m_cs = 1; m_ch = (seq_table >> (4 * m_slot)) & 32'hF;
            end else if (conv_done) begin
                m_busy = 0; m_rv = 1; m_rslot = m_slot; m_rdata = conv_data;
                ending = (one_mode != 0 || m_slot == 7) ? 1 : 0;
                if (ending != 0) begin
                    m_slot = 0;
                    m_irq = irq_en ? 1 : 0;
                    if (loop_mode == 0) m_start = 0;
                end else begin
                    m_slot = m_slot + 1;
                end
            end
            if (sw_wr) m_start = sw_val ? 1 : 0;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check("R8",  "conv_start", int'(conv_start), m_cs);
            check("R3",  "ch_sel",     int'(ch_sel),     m_ch);
            check("R9",  "res_valid",  int'(res_valid),  m_rv);
            check("R9",  "res_slot",   int'(res_slot),   m_rslot);
            check("R9",  "res_data",   int'(res_data),   m_rdata);
            check("R10", "eoc_irq",    int'(eoc_irq),    m_irq);
            check("R11", "start_bit",  int'(start_bit),  m_start);
        end
    end

    // event counters
    int cs_cnt = 0, rv_cnt = 0, irq_cnt = 0;
    always @(negedge clk) begin
        if (conv_start) cs_cnt++;
        if (res_valid)  rv_cnt++;
        if (eoc_irq)    irq_cnt++;
    end

    // converter stand-in: answers each start after lat cycles
    int lat = 2;
    int countdown = 0;
    logic [11:0] seed = 12'h155;
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (conv_start) begin
            countdown = lat;
        end else if (countdown > 0) begin
            countdown--;
            if (countdown == 0) begin
                conv_done = 1'b1;
                conv_data = seed;
                seed = seed + 12'd37;
            end
        end
    end

    task automatic sw_write(input logic v);
        @(negedge clk); sw_wr = 1'b1; sw_val = v;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic wait_start_low();
        for (int i = 0; i < 400 && start_bit; i++) @(negedge clk);
    endtask

    task automatic wait_results(input int n);
        int target = rv_cnt + n;
        for (int i = 0; i < 2000 && rv_cnt < target; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int c0, r0, i0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "start_bit in reset",  int'(start_bit),  0);
        check("R1", "conv_start in reset", int'(conv_start), 0);
        check("R1", "res_valid in reset",  int'(res_valid),  0);
        check("R1", "eoc_irq in reset",    int'(eoc_irq),    0);
        check("R1", "outputs in reset", int'(ch_sel) + int'(res_slot) + int'(res_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "start_bit after reset", int'(start_bit), 0);
        conv_en = 1'b1; irq_en = 1'b1;

        // R2: single conversion, mode 0 then reserved mode 1
        for (int m = 0; m < 2; m++) begin
            run_mode = 2'(m);
            c0 = cs_cnt; i0 = irq_cnt;
            sw_write(1'b1);
            wait_start_low();
            repeat (4) @(negedge clk);
            check("R2", "single conversion count", cs_cnt - c0, 1);
            check("R10", "single conversion irq", irq_cnt - i0, 1);
            check("R11", "start bit cleared", int'(start_bit), 0);
        end

        // R3: one pass over all slots
        run_mode = 2'd2; lat = 3;
        c0 = cs_cnt; r0 = rv_cnt; i0 = irq_cnt;
        sw_write(1'b1);
        wait_start_low();
        repeat (5) @(negedge clk);
        check("R3", "pass conversion count", cs_cnt - c0, 8);
        check("R9", "pass result count", rv_cnt - r0, 8);
        check("R10", "pass irq count", irq_cnt - i0, 1);

        // R4: repeating pass
        run_mode = 2'd3; lat = 1;
        i0 = irq_cnt;
        sw_write(1'b1);
        wait_results(20);
        check("R4", "start bit held in loop", int'(start_bit), 1);
        check("R4", "loop wrapped twice", (irq_cnt - i0 >= 2) ? 1 : 0, 1);
        sw_write(1'b0);
        repeat (3) @(negedge clk);
        c0 = cs_cnt;
        repeat (12) @(negedge clk);
        check("R6", "no start after stop", cs_cnt - c0, 0);

        // R5: down-sample enable overrides mode 0
        run_mode = 2'd0; ds_en = 1'b1; lat = 2;
        sw_write(1'b1);
        wait_results(12);
        check("R5", "start bit held with ds_en", int'(start_bit), 1);

        // R6: stop while a conversion is outstanding, late done ignored
        lat = 6;
        for (int i = 0; i < 100 && !conv_start; i++) @(negedge clk);
        sw_write(1'b0);
        r0 = rv_cnt; c0 = cs_cnt;
        repeat (15) @(negedge clk);
        check("R6", "late done gives no result", rv_cnt - r0, 0);
        check("R6", "no start after abort", cs_cnt - c0, 0);
        ds_en = 1'b0; lat = 2;

        // R7: converter enable low holds the run
        conv_en = 1'b0; run_mode = 2'd0;
        c0 = cs_cnt;
        sw_write(1'b1);
        repeat (30) @(negedge clk);
        check("R7", "no start while disabled", cs_cnt - c0, 0);
        conv_en = 1'b1;
        wait_start_low();
        repeat (3) @(negedge clk);
        check("R7", "run after enable", cs_cnt - c0, 1);

        // R10: interrupt suppressed
        irq_en = 1'b0; run_mode = 2'd2; seq_table = 32'h0F1E_2D3C;
        i0 = irq_cnt;
        sw_write(1'b1);
        wait_start_low();
        repeat (4) @(negedge clk);
        check("R10", "no irq when disabled", irq_cnt - i0, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule